// File: doc/BRIEF.md
# Hot-Flow Queue Classifier

This block sits at the input port of a network switch and decides, for every arriving packet, which of the port's five packet queues receives it: a single cold queue or one of four hot queues. A hot queue belongs to one congestion root. The root is held as a ternary pattern over the 6-bit destination ID, so one entry captures every destination whose route crosses that root. For example, a pattern such as `xx0000` or `xxxx00` covers a whole group of destinations. Each entry also holds the hop distance to the root and an output port. A packet that hits no valid entry takes the cold queue.

Congestion detection lies outside the block. It delivers a root as an install request, and the root may sit anywhere in the network. The block places the request in the lowest free slot, acknowledges it, and emits a copy with the hop count reduced by one for the switch one stage upstream. A slot is returned only when its hot queue has drained and a release is requested. At most four trees can be tracked at once. Once the table is full, further requests are dropped and a saturation flag is raised, and their traffic stays in the cold queue.

Top module: `hot_flow_classifier`

## Requirements
- R1: With `pkt_valid_i` high, a destination D matches entry k when `((D ^ value_k) & care_k) == 0` (a care bit of 1 means the bit is compared). In the same cycle, `q_sel_o` = k+1 and `q_hot_o` = 1, so codes 1..4 name hot queues 0..3.
- R2: When no valid entry matches, or `pkt_valid_i` is low, `q_sel_o` = 0 (the cold queue) and `q_hot_o` = 0.
- R3: When several entries match, the entry with the most care bits wins. Among entries with equal care counts, the lowest index wins.
- R4: On a hit, `hit_hops_o` and `hit_port_o` show the winning entry's hop count and output port. With no hit, both are zero.
- R5: An accepted new install is written into the lowest-numbered free slot. One cycle after `install_i`, `inst_done_o` = 1, `inst_ok_o` = 1 and `inst_slot_o` = the slot. The entry affects lookups from the next cycle on, and never in the install cycle itself.
- R6: An install that finds no free slot and no duplicate is dropped. One cycle later, `inst_done_o` = 1, `inst_ok_o` = 0 and `sat_o` = 1. Destinations of the dropped root keep going to the cold queue.
- R7: `sat_o` stays at 1 until a slot is freed in a cycle with no dropped install. It then reads 0 from the next cycle on.
- R8: Slot k is freed only in a cycle where `release_i[k]` and `hq_empty_i[k]` are both 1. A release while the queue is not empty leaves the entry matching.
- R9: One cycle after an accepted new install whose hop count H is above 0, `prop_valid_o` = 1 with `prop_val_o` = value & care, `prop_care_o` = care and `prop_hops_o` = H-1. When H is 0, no message is sent.
- R10: An install whose care mask and masked value equal those of a valid entry takes no slot. It is acknowledged with `inst_ok_o` = 1 and that entry's slot, leaves the entry unchanged, and sends no message.
- R11: Installs and frees both act on the table as it stood at the start of the cycle. On a full table, an install in the same cycle as a free is dropped.
- R12: After reset, all slots are free and `q_sel_o`, `inst_done_o`, `sat_o` and `prop_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid_i | input | 1 | A packet header is present |
| pkt_dest_i | input | 6 | Destination ID of the packet |
| q_sel_o | output | 3 | Queue code: 0 cold, k+1 hot queue k |
| q_hot_o | output | 1 | Packet hit a congestion root |
| hit_hops_o | output | 4 | Hop count of the winning entry |
| hit_port_o | output | 3 | Output port of the winning entry |
| install_i | input | 1 | Install-root request |
| inst_val_i | input | 6 | Root destination pattern value |
| inst_care_i | input | 6 | Root care mask, 1 = compared bit |
| inst_hops_i | input | 4 | Distance to the root |
| inst_port_i | input | 3 | Output port toward the root |
| inst_done_o | output | 1 | Install outcome is valid (one cycle) |
| inst_ok_o | output | 1 | Install accepted or duplicate |
| inst_slot_o | output | 2 | Slot used by the install |
| sat_o | output | 1 | An install was dropped on a full table |
| release_i | input | 4 | Per-slot release request |
| hq_empty_i | input | 4 | Per-slot hot queue is empty |
| prop_valid_o | output | 1 | Upstream root message valid |
| prop_val_o | output | 6 | Message pattern value |
| prop_care_o | output | 6 | Message care mask |
| prop_hops_o | output | 4 | Message hop count (one lower) |

## Verification
A slot release and an install request can land in the same cycle, and the case that matters is a full table. The bench fills all four slots, asserts an install together with a release whose queue is empty, and expects the install to be dropped with saturation held. It then expects the released slot's destinations to go to the cold queue, and a later install to reuse that slot. A second overlap places a lookup in the same cycle as the install that creates its matching entry. That packet must still go cold, and the same destination must go to the new hot queue one cycle later.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

   // Outcome of an install request, decided in the request cycle
   typedef enum logic [1:0] {
      INST_NONE = 2'd0,
      INST_NEW  = 2'd1,
      INST_DUP  = 2'd2,
      INST_DROP = 2'd3
   } inst_kind_e;

   localparam int unsigned DEF_DEST_W  = 6;
   localparam int unsigned DEF_NUM_HOT = 4;
   localparam int unsigned DEF_HOP_W   = 4;
   localparam int unsigned DEF_PORT_W  = 3;

endpackage

// File: rtl/hfc_entry_table.sv
module hfc_entry_table
   import hfc_pkg::*;
#(
   parameter int unsigned DEST_W  = DEF_DEST_W,
   parameter int unsigned NUM_HOT = DEF_NUM_HOT,
   parameter int unsigned HOP_W   = DEF_HOP_W,
   parameter int unsigned PORT_W  = DEF_PORT_W,
   localparam int unsigned SLOT_W = (NUM_HOT > 1) ? $clog2(NUM_HOT) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             install_i,
   input  logic [DEST_W-1:0]                inst_val_i,
   input  logic [DEST_W-1:0]                inst_care_i,
   input  logic [HOP_W-1:0]                 inst_hops_i,
   input  logic [PORT_W-1:0]                inst_port_i,
   input  logic [NUM_HOT-1:0]               release_i,
   input  logic [NUM_HOT-1:0]               hq_empty_i,
   output logic [NUM_HOT-1:0]               ent_valid_o,
   output logic [NUM_HOT-1:0][DEST_W-1:0]   ent_val_o,
   output logic [NUM_HOT-1:0][DEST_W-1:0]   ent_care_o,
   output logic [NUM_HOT-1:0][HOP_W-1:0]    ent_hops_o,
   output logic [NUM_HOT-1:0][PORT_W-1:0]   ent_port_o,
   output inst_kind_e                       dec_kind_o,
   output logic [SLOT_W-1:0]                dec_slot_o,
   output logic                             free_any_o
);

   logic [DEST_W-1:0]  val_norm;
   logic               dup_hit;
   logic [SLOT_W-1:0]  dup_idx;
   logic               free_hit;
   logic [SLOT_W-1:0]  free_idx;
   logic [NUM_HOT-1:0] frees;

   assign val_norm = inst_val_i & inst_care_i;
   assign frees    = ent_valid_o & release_i & hq_empty_i;
   assign free_any_o = |frees;

   // Duplicate search and lowest free slot search over the registered table
   always_comb begin
      dup_hit  = 1'b0;
      dup_idx  = '0;
      free_hit = 1'b0;
      free_idx = '0;
      for (int k = NUM_HOT - 1; k >= 0; k--) begin
         if (ent_valid_o[k] && (ent_care_o[k] == inst_care_i) && (ent_val_o[k] == val_norm)) begin
            dup_hit = 1'b1;
            dup_idx = SLOT_W'(k);
         end
         if (!ent_valid_o[k]) begin
            free_hit = 1'b1;
            free_idx = SLOT_W'(k);
         end
      end
   end

   always_comb begin
      dec_kind_o = INST_NONE;
      dec_slot_o = '0;
      if (install_i) begin
         if (dup_hit) begin
            dec_kind_o = INST_DUP;
            dec_slot_o = dup_idx;
         end else if (free_hit) begin
            dec_kind_o = INST_NEW;
            dec_slot_o = free_idx;
         end else begin
            dec_kind_o = INST_DROP;
         end
      end
   end

   generate
      for (genvar k = 0; k < NUM_HOT; k++) begin : g_slot
         logic wr_here;
         assign wr_here = (dec_kind_o == INST_NEW) && (dec_slot_o == SLOT_W'(k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_valid_o[k] <= 1'b0;
               ent_val_o[k]   <= '0;
               ent_care_o[k]  <= '0;
               ent_hops_o[k]  <= '0;
               ent_port_o[k]  <= '0;
            end else if (wr_here) begin
               ent_valid_o[k] <= 1'b1;
               ent_val_o[k]   <= val_norm;
               ent_care_o[k]  <= inst_care_i;
               ent_hops_o[k]  <= inst_hops_i;
               ent_port_o[k]  <= inst_port_i;
            end else if (frees[k]) begin
               ent_valid_o[k] <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hfc_match_unit.sv
module hfc_match_unit
   import hfc_pkg::*;
#(
   parameter int unsigned DEST_W  = DEF_DEST_W,
   parameter int unsigned NUM_HOT = DEF_NUM_HOT,
   parameter int unsigned HOP_W   = DEF_HOP_W,
   parameter int unsigned PORT_W  = DEF_PORT_W,
   localparam int unsigned SLOT_W = (NUM_HOT > 1) ? $clog2(NUM_HOT) : 1,
   localparam int unsigned CNT_W  = $clog2(DEST_W + 1)
) (
   input  logic                             pkt_valid_i,
   input  logic [DEST_W-1:0]                pkt_dest_i,
   input  logic [NUM_HOT-1:0]               ent_valid_i,
   input  logic [NUM_HOT-1:0][DEST_W-1:0]   ent_val_i,
   input  logic [NUM_HOT-1:0][DEST_W-1:0]   ent_care_i,
   input  logic [NUM_HOT-1:0][HOP_W-1:0]    ent_hops_i,
   input  logic [NUM_HOT-1:0][PORT_W-1:0]   ent_port_i,
   output logic                             hit_o,
   output logic [SLOT_W-1:0]                win_o,
   output logic [HOP_W-1:0]                 hops_o,
   output logic [PORT_W-1:0]                port_o
);

   logic [NUM_HOT-1:0]            hitv;
   logic [NUM_HOT-1:0][CNT_W-1:0] weight;

   generate
      for (genvar k = 0; k < NUM_HOT; k++) begin : g_cmp
         assign hitv[k]   = pkt_valid_i && ent_valid_i[k] &&
                            (((pkt_dest_i ^ ent_val_i[k]) & ent_care_i[k]) == '0);
         assign weight[k] = CNT_W'($countones(ent_care_i[k]));
      end
   endgenerate

   // Most specific entry wins; strict compare keeps the lower index on ties
   always_comb begin
      logic [CNT_W-1:0] best_w;
      hit_o  = 1'b0;
      win_o  = '0;
      best_w = '0;
      for (int k = 0; k < NUM_HOT; k++) begin
         if (hitv[k] && (!hit_o || (weight[k] > best_w))) begin
            hit_o  = 1'b1;
            win_o  = SLOT_W'(k);
            best_w = weight[k];
         end
      end
   end

   assign hops_o = hit_o ? ent_hops_i[win_o] : '0;
   assign port_o = hit_o ? ent_port_i[win_o] : '0;

endmodule

// File: rtl/hfc_notify.sv
module hfc_notify
   import hfc_pkg::*;
#(
   parameter int unsigned DEST_W  = DEF_DEST_W,
   parameter int unsigned NUM_HOT = DEF_NUM_HOT,
   parameter int unsigned HOP_W   = DEF_HOP_W,
   localparam int unsigned SLOT_W = (NUM_HOT > 1) ? $clog2(NUM_HOT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  inst_kind_e          dec_kind_i,
   input  logic [SLOT_W-1:0]   dec_slot_i,
   input  logic                free_any_i,
   input  logic [DEST_W-1:0]   inst_val_i,
   input  logic [DEST_W-1:0]   inst_care_i,
   input  logic [HOP_W-1:0]    inst_hops_i,
   output logic                done_o,
   output logic                ok_o,
   output logic [SLOT_W-1:0]   slot_o,
   output logic                sat_o,
   output logic                prop_valid_o,
   output logic [DEST_W-1:0]   prop_val_o,
   output logic [DEST_W-1:0]   prop_care_o,
   output logic [HOP_W-1:0]    prop_hops_o
);

   logic send;
   assign send = (dec_kind_i == INST_NEW) && (inst_hops_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o       <= 1'b0;
         ok_o         <= 1'b0;
         slot_o       <= '0;
         sat_o        <= 1'b0;
         prop_valid_o <= 1'b0;
         prop_val_o   <= '0;
         prop_care_o  <= '0;
         prop_hops_o  <= '0;
      end else begin
         done_o <= (dec_kind_i != INST_NONE);
         ok_o   <= (dec_kind_i == INST_NEW) || (dec_kind_i == INST_DUP);
         slot_o <= (dec_kind_i == INST_DROP) ? '0 : dec_slot_i;
         if (dec_kind_i == INST_DROP) begin
            sat_o <= 1'b1;
         end else if (free_any_i) begin
            sat_o <= 1'b0;
         end
         prop_valid_o <= send;
         prop_val_o   <= send ? (inst_val_i & inst_care_i) : '0;
         prop_care_o  <= send ? inst_care_i : '0;
         prop_hops_o  <= send ? (inst_hops_i - HOP_W'(1)) : '0;
      end
   end

endmodule

// File: rtl/hot_flow_classifier.sv
module hot_flow_classifier
   import hfc_pkg::*;
#(
   parameter int unsigned DEST_W  = DEF_DEST_W,
   parameter int unsigned NUM_HOT = DEF_NUM_HOT,
   parameter int unsigned HOP_W   = DEF_HOP_W,
   parameter int unsigned PORT_W  = DEF_PORT_W,
   localparam int unsigned SLOT_W = (NUM_HOT > 1) ? $clog2(NUM_HOT) : 1,
   localparam int unsigned QSEL_W = $clog2(NUM_HOT + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pkt_valid_i,
   input  logic [DEST_W-1:0]    pkt_dest_i,
   output logic [QSEL_W-1:0]    q_sel_o,
   output logic                 q_hot_o,
   output logic [HOP_W-1:0]     hit_hops_o,
   output logic [PORT_W-1:0]    hit_port_o,
   input  logic                 install_i,
   input  logic [DEST_W-1:0]    inst_val_i,
   input  logic [DEST_W-1:0]    inst_care_i,
   input  logic [HOP_W-1:0]     inst_hops_i,
   input  logic [PORT_W-1:0]    inst_port_i,
   output logic                 inst_done_o,
   output logic                 inst_ok_o,
   output logic [SLOT_W-1:0]    inst_slot_o,
   output logic                 sat_o,
   input  logic [NUM_HOT-1:0]   release_i,
   input  logic [NUM_HOT-1:0]   hq_empty_i,
   output logic                 prop_valid_o,
   output logic [DEST_W-1:0]    prop_val_o,
   output logic [DEST_W-1:0]    prop_care_o,
   output logic [HOP_W-1:0]     prop_hops_o
);

   generate
      if (DEST_W < 1) begin : g_bad_dest
         $error("DEST_W must be at least 1");
      end
      if (NUM_HOT < 1) begin : g_bad_hot
         $error("NUM_HOT must be at least 1");
      end
      if (HOP_W < 1) begin : g_bad_hop
         $error("HOP_W must be at least 1");
      end
      if (PORT_W < 1) begin : g_bad_port
         $error("PORT_W must be at least 1");
      end
   endgenerate

   logic [NUM_HOT-1:0]             ent_valid;
   logic [NUM_HOT-1:0][DEST_W-1:0] ent_val;
   logic [NUM_HOT-1:0][DEST_W-1:0] ent_care;
   logic [NUM_HOT-1:0][HOP_W-1:0]  ent_hops;
   logic [NUM_HOT-1:0][PORT_W-1:0] ent_port;
   inst_kind_e                     dec_kind;
   logic [SLOT_W-1:0]              dec_slot;
   logic                           free_any;
   logic                           hit;
   logic [SLOT_W-1:0]              win;

   hfc_entry_table #(
      .DEST_W(DEST_W), .NUM_HOT(NUM_HOT), .HOP_W(HOP_W), .PORT_W(PORT_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .install_i   (install_i),
      .inst_val_i  (inst_val_i),
      .inst_care_i (inst_care_i),
      .inst_hops_i (inst_hops_i),
      .inst_port_i (inst_port_i),
      .release_i   (release_i),
      .hq_empty_i  (hq_empty_i),
      .ent_valid_o (ent_valid),
      .ent_val_o   (ent_val),
      .ent_care_o  (ent_care),
      .ent_hops_o  (ent_hops),
      .ent_port_o  (ent_port),
      .dec_kind_o  (dec_kind),
      .dec_slot_o  (dec_slot),
      .free_any_o  (free_any)
   );

   hfc_match_unit #(
      .DEST_W(DEST_W), .NUM_HOT(NUM_HOT), .HOP_W(HOP_W), .PORT_W(PORT_W)
   ) u_match (
      .pkt_valid_i (pkt_valid_i),
      .pkt_dest_i  (pkt_dest_i),
      .ent_valid_i (ent_valid),
      .ent_val_i   (ent_val),
      .ent_care_i  (ent_care),
      .ent_hops_i  (ent_hops),
      .ent_port_i  (ent_port),
      .hit_o       (hit),
      .win_o       (win),
      .hops_o      (hit_hops_o),
      .port_o      (hit_port_o)
   );

   hfc_notify #(
      .DEST_W(DEST_W), .NUM_HOT(NUM_HOT), .HOP_W(HOP_W)
   ) u_notify (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_kind_i   (dec_kind),
      .dec_slot_i   (dec_slot),
      .free_any_i   (free_any),
      .inst_val_i   (inst_val_i),
      .inst_care_i  (inst_care_i),
      .inst_hops_i  (inst_hops_i),
      .done_o       (inst_done_o),
      .ok_o         (inst_ok_o),
      .slot_o       (inst_slot_o),
      .sat_o        (sat_o),
      .prop_valid_o (prop_valid_o),
      .prop_val_o   (prop_val_o),
      .prop_care_o  (prop_care_o),
      .prop_hops_o  (prop_hops_o)
   );

   // Queue code 0 is cold; hot queue k is code k+1
   assign q_hot_o = hit;
   assign q_sel_o = hit ? (QSEL_W'(win) + QSEL_W'(1)) : '0;

endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
   parameter int unsigned NUM_HOT = 4,
   localparam int unsigned QSEL_W = $clog2(NUM_HOT + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pkt_valid_i,
   input logic               install_i,
   input logic [NUM_HOT-1:0] release_i,
   input logic [QSEL_W-1:0]  q_sel_o,
   input logic               q_hot_o,
   input logic               inst_done_o,
   input logic               inst_ok_o,
   input logic               sat_o,
   input logic               prop_valid_o
);

   assert_hot_code_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q_hot_o |-> ((q_sel_o != '0) && (q_sel_o <= QSEL_W'(NUM_HOT))));

   assert_idle_is_cold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid_i |-> (!q_hot_o && (q_sel_o == '0)));

   assert_install_answered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      install_i |=> inst_done_o);

   assert_no_spurious_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !install_i |=> !inst_done_o);

   assert_drop_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_done_o && !inst_ok_o) |-> sat_o);

   assert_sat_clears_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sat_o) |-> $past(|release_i));

   assert_prop_only_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      prop_valid_o |-> (inst_done_o && inst_ok_o));

endmodule

bind hot_flow_classifier hfc_checker #(.NUM_HOT(NUM_HOT)) u_hfc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .pkt_valid_i  (pkt_valid_i),
   .install_i    (install_i),
   .release_i    (release_i),
   .q_sel_o      (q_sel_o),
   .q_hot_o      (q_hot_o),
   .inst_done_o  (inst_done_o),
   .inst_ok_o    (inst_ok_o),
   .sat_o        (sat_o),
   .prop_valid_o (prop_valid_o)
);

// File: tb/hot_flow_classifier_test.sv
`timescale 1ns/1ps
module hot_flow_classifier_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_valid_i = 1'b0;
   logic [5:0] pkt_dest_i = '0;
   logic [2:0] q_sel_o;
   logic       q_hot_o;
   logic [3:0] hit_hops_o;
   logic [2:0] hit_port_o;
   logic       install_i = 1'b0;
   logic [5:0] inst_val_i = '0;
   logic [5:0] inst_care_i = '0;
   logic [3:0] inst_hops_i = '0;
   logic [2:0] inst_port_i = '0;
   logic       inst_done_o;
   logic       inst_ok_o;
   logic [1:0] inst_slot_o;
   logic       sat_o;
   logic [3:0] release_i = '0;
   logic [3:0] hq_empty_i = '0;
   logic       prop_valid_o;
   logic [5:0] prop_val_o;
   logic [5:0] prop_care_o;
   logic [3:0] prop_hops_o;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   hot_flow_classifier uut (.*);

   // {dest[6], expected queue code[3], expected hops[4], expected port[3]}
   localparam int NV = 8;
   localparam logic [15:0] VEC [NV] = '{
      {6'b000000, 3'd1, 4'd3, 3'd2},   // R3: slot0 (4 care) beats slot1 (2 care)
      {6'b010100, 3'd2, 4'd0, 3'd5},   // R1: only slot1
      {6'b101010, 3'd3, 4'd1, 3'd1},   // R1: exact slot2
      {6'b110000, 3'd1, 4'd3, 3'd2},   // R3: slot0 over slot1 and slot3
      {6'b111101, 3'd4, 4'd7, 3'd6},   // R4: only slot3
      {6'b000001, 3'd0, 4'd0, 3'd0},   // R2: no match
      {6'b111100, 3'd2, 4'd0, 3'd5},   // R3: tie slot1/slot3 -> lower index
      {6'b101011, 3'd0, 4'd0, 3'd0}    // R2: no match
   };

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic look(input string req, input logic [5:0] d, input int sel);
      pkt_valid_i = 1'b1;
      pkt_dest_i  = d;
      #1;
      chk(req, int'(q_sel_o), sel);
   endtask

   // Drive an install for one cycle; outcome is visible after the edge
   task automatic do_install(input logic [5:0] v, input logic [5:0] c,
                             input logic [3:0] h, input logic [2:0] p);
      install_i   = 1'b1;
      inst_val_i  = v;
      inst_care_i = c;
      inst_hops_i = h;
      inst_port_i = p;
      tick();
      install_i = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();

      // R12: reset state
      look("R12 cold after reset", 6'b000000, 0);
      chk("R12 done low", int'(inst_done_o), 0);
      chk("R12 sat low", int'(sat_o), 0);
      chk("R12 prop low", int'(prop_valid_o), 0);

      // R5: the entry does not act in its own install cycle
      install_i = 1'b1; inst_val_i = 6'b000000; inst_care_i = 6'b001111;
      inst_hops_i = 4'd3; inst_port_i = 3'd2;
      pkt_valid_i = 1'b1; pkt_dest_i = 6'b000000;
      #1;
      chk("R5 no hit in install cycle", int'(q_sel_o), 0);
      tick();
      install_i = 1'b0;
      #1;
      chk("R5 done", int'(inst_done_o), 1);
      chk("R5 ok", int'(inst_ok_o), 1);
      chk("R5 slot0", int'(inst_slot_o), 0);
      chk("R9 prop valid", int'(prop_valid_o), 1);
      chk("R9 prop care", int'(prop_care_o), 6'b001111);
      chk("R9 prop hops minus one", int'(prop_hops_o), 2);
      chk("R5 hit next cycle", int'(q_sel_o), 1);

      do_install(6'b000000, 6'b000011, 4'd0, 3'd5);
      chk("R5 slot1", int'(inst_slot_o), 1);
      chk("R9 no prop at zero hops", int'(prop_valid_o), 0);
      do_install(6'b101010, 6'b111111, 4'd1, 3'd1);
      chk("R5 slot2", int'(inst_slot_o), 2);
      chk("R9 prop hops zero", int'(prop_hops_o), 0);
      do_install(6'b111111, 6'b110000, 4'd7, 3'd6);
      chk("R5 slot3", int'(inst_slot_o), 3);
      chk("R9 prop value masked", int'(prop_val_o), 6'b110000);

      // Vector walk: R1 R3 R4 R2
      for (int i = 0; i < NV; i++) begin
         look("R1/R3 vector queue", VEC[i][15:10], int'(VEC[i][9:7]));
         chk("R4 vector hops", int'(hit_hops_o), int'(VEC[i][6:3]));
         chk("R4 vector port", int'(hit_port_o), int'(VEC[i][2:0]));
         chk("R1 hot flag", int'(q_hot_o), int'(VEC[i][9:7] != 3'd0));
      end

      // R2: matching destination without valid
      pkt_valid_i = 1'b0; pkt_dest_i = 6'b101010;
      #1;
      chk("R2 idle cold", int'(q_sel_o), 0);

      // R10: duplicate on a full table
      do_install(6'b110000, 6'b001111, 4'd9, 3'd7);
      chk("R10 dup ok", int'(inst_ok_o), 1);
      chk("R10 dup slot", int'(inst_slot_o), 0);
      chk("R10 dup no prop", int'(prop_valid_o), 0);
      chk("R10 no saturation", int'(sat_o), 0);
      look("R10 entry unchanged", 6'b000000, 1);
      chk("R10 hops unchanged", int'(hit_hops_o), 3);

      // R6: drop on full table
      do_install(6'b000111, 6'b111111, 4'd2, 3'd3);
      chk("R6 drop not ok", int'(inst_ok_o), 0);
      chk("R6 sat set", int'(sat_o), 1);
      chk("R6 no prop", int'(prop_valid_o), 0);
      look("R6 dropped root cold", 6'b000111, 0);

      // R8: release with a busy queue is ignored
      release_i = 4'b0100; hq_empty_i = 4'b0000;
      tick();
      release_i = '0;
      look("R8 busy release ignored", 6'b101010, 3);
      chk("R7 sat held without free", int'(sat_o), 1);

      // R11: free and install in one cycle on a full table
      release_i = 4'b0100; hq_empty_i = 4'b0100;
      do_install(6'b000111, 6'b111111, 4'd2, 3'd3);
      release_i = '0; hq_empty_i = '0;
      chk("R11 install dropped", int'(inst_ok_o), 0);
      chk("R11 sat held", int'(sat_o), 1);
      look("R8 freed slot goes cold", 6'b101010, 0);

      // R7: free alone clears saturation
      release_i = 4'b1000; hq_empty_i = 4'b1000;
      tick();
      release_i = '0; hq_empty_i = '0;
      chk("R7 sat cleared", int'(sat_o), 0);
      look("R8 slot3 freed", 6'b111101, 0);

      // R5: lowest free slot reused
      do_install(6'b000111, 6'b111111, 4'd5, 3'd4);
      chk("R5 reuse slot2", int'(inst_slot_o), 2);
      chk("R9 prop hops four", int'(prop_hops_o), 4);
      look("R5 new entry hit", 6'b000111, 3);
      chk("R4 new entry port", int'(hit_port_o), 4);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule